// File: doc/BRIEF.md
# SPI Status Flag Handshake

This block is the host-facing register front end of an SPI peripheral. It keeps three event flags: receive-full, transmit-empty and mode-fault. The host cannot clear a flag with one access. It must first read the status register while the flag is 1, which arms that flag. It must then make the matching access: a read of the data low byte, a write of the data low byte, or a write to control register 1. Accesses to the data high byte never clear a flag. In wide mode this lets software move a 16-bit word one byte at a time, high byte first.

The shift engine is represented only by strobes. A transfer-done pulse delivers a received word. A load-taken pulse reports that the shifter has consumed the transmit holding word. A slave-select input is watched for a falling edge while the unit is master.

Top module: `spi_flag_frontend`

## Requirements
- R1: After reset, tx_empty_o is 1, rx_full_o and mode_fault_o are 0, and no flag is armed. A data low-byte read right after the first transfer, with no status read before it, leaves rx_full_o at 1.
- R2: An eng_done pulse sets rx_full_o on the next cycle and latches eng_rx_word. A status read (host_addr 0) returns rx_full in bit 0, tx_empty in bit 1 and mode_fault in bit 2, with zeros above.
- R3: rx_full_o clears only when a status read that saw it at 1 is followed by a data read (host_addr 3) with host_be[0]=1. Once the flag has cleared, its arming is gone, so a later transfer needs a fresh status read.
- R4: A data read with host_be=2'b10 (high byte only) never changes rx_full_o or its arming, however often it repeats.
- R5: Bit 1 of control register 1 (host_addr 1) selects wide mode. In wide mode a data read returns the whole received word. In narrow mode it returns the low byte with zeros above.
- R6: eng_load_taken sets tx_empty_o on the next cycle. Any data write while tx_empty_o is 0 is ignored, and tx_word_o keeps its value.
- R7: tx_empty_o clears only when a status read that saw it at 1 is followed by a data write with host_be[0]=1. A word write loads both bytes. A low-byte write made without arming stores the data but leaves the flag at 1. In narrow mode the upper byte of tx_word_o is 0.
- R8: A data write with host_be=2'b10 while tx_empty_o is 1 stores the high byte and does not change the flag. Repeated high-byte writes are allowed, and the last one wins.
- R9: mode_fault_o sets when ss_in_n falls while control register 1 bit 0 (master) and control register 2 bit 0 (fault detect enable) are both 1. Otherwise a falling edge has no effect.
- R10: mode_fault_o clears only when a status read that saw it at 1 is followed by a write to control register 1.
- R11: If eng_done arrives in the same cycle as a clearing data read, rx_full_o stays 1 and the new word is the one held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | Single-cycle host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | 0 status, 1 control 1, 2 control 2, 3 data |
| host_be | input | 2 | Byte lanes: bit 0 low byte, bit 1 high byte |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for the addressed register (combinational) |
| eng_done | input | 1 | Transfer-complete strobe from the shift engine |
| eng_rx_word | input | 16 | Received word, valid with eng_done |
| eng_load_taken | input | 1 | Shifter has taken the holding word |
| ss_in_n | input | 1 | Slave-select input, active low |
| tx_word_o | output | 16 | Transmit holding word presented to the shifter |
| rx_full_o | output | 1 | Receive-full flag |
| tx_empty_o | output | 1 | Transmit-empty flag |
| mode_fault_o | output | 1 | Mode-fault flag |
| master_o | output | 1 | Control register 1 master bit |
| wide_o | output | 1 | Control register 1 wide-mode bit |

## Verification
The assertions assume the host issues at most one access per cycle, as single-cycle strobes that stay synchronous to clk. They also assume the engine strobes are single-cycle pulses and that ss_in_n is already synchronised. The bench drives every input on the falling clock edge, holds each strobe for exactly one cycle, and never overlaps two host accesses. Only the same-cycle transfer-done and clearing read are combined on purpose, to reach the set-over-clear corner.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_CTRL1  = 2'd1,
    REG_CTRL2  = 2'd2,
    REG_DATA   = 2'd3
  } reg_sel_e;

  localparam int FLAG_N   = 3;
  localparam int ST_RXF   = 0;
  localparam int ST_TXE   = 1;
  localparam int ST_MF    = 2;

  localparam int C1_MASTER = 0;
  localparam int C1_WIDE   = 1;
  localparam int C1_W      = 2;
  localparam int C2_FDEN   = 0;
endpackage

// File: rtl/spi_flag_cell.sv
module spi_flag_cell #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic seen_i,
  input  logic access_i,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, flag_d;
  logic armed_q, armed_d;
  logic clear_fire;

  always_comb begin
    clear_fire = access_i & armed_q;
    if (set_i)           flag_d = 1'b1;
    else if (clear_fire) flag_d = 1'b0;
    else                 flag_d = flag_q;

    if (access_i)                armed_d = 1'b0;
    else if (seen_i && flag_q)   armed_d = 1'b1;
    else                         armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= RESET_VAL;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/spi_rx_buffer.sv
module spi_rx_buffer #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [2*BYTE_W-1:0] word_i,
  input  logic                wide_i,
  output logic [2*BYTE_W-1:0] rd_word_o
);
  localparam int DATA_W = 2 * BYTE_W;

  logic [DATA_W-1:0] buf_q, buf_d;

  always_comb begin
    buf_d = buf_q;
    if (load_i) buf_d = word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else        buf_q <= buf_d;
  end

  always_comb begin
    if (wide_i) rd_word_o = buf_q;
    else        rd_word_o = {{BYTE_W{1'b0}}, buf_q[BYTE_W-1:0]};
  end
endmodule

// File: rtl/spi_tx_holding.sv
module spi_tx_holding #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [2*BYTE_W-1:0] wdata_i,
  input  logic                wide_i,
  output logic [2*BYTE_W-1:0] tx_word_o
);
  localparam int DATA_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_q, lo_d, hi_q, hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (wr_lo_i) lo_d = wdata_i[BYTE_W-1:0];
    if (wr_hi_i) hi_d = wdata_i[DATA_W-1:BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  always_comb begin
    if (wide_i) tx_word_o = {hi_q, lo_q};
    else        tx_word_o = {{BYTE_W{1'b0}}, lo_q};
  end
endmodule

// File: rtl/spi_flag_frontend.sv
module spi_flag_frontend
  import spi_flag_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_req,
  input  logic                host_wr,
  input  logic [1:0]          host_addr,
  input  logic [1:0]          host_be,
  input  logic [2*BYTE_W-1:0] host_wdata,
  output logic [2*BYTE_W-1:0] host_rdata,
  input  logic                eng_done,
  input  logic [2*BYTE_W-1:0] eng_rx_word,
  input  logic                eng_load_taken,
  input  logic                ss_in_n,
  output logic [2*BYTE_W-1:0] tx_word_o,
  output logic                rx_full_o,
  output logic                tx_empty_o,
  output logic                mode_fault_o,
  output logic                master_o,
  output logic                wide_o
);
  localparam int DATA_W = 2 * BYTE_W;
  localparam logic [FLAG_N-1:0] FLAG_RST = FLAG_N'(1) << ST_TXE;

  // reset: asserted asynchronously, released after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  // access decode
  reg_sel_e sel;
  logic acc_rd, acc_wr;
  logic st_rd, dat_rd_lo, dat_wr_lo_try, dat_wr_hi_try, c1_wr, c2_wr;
  logic tx_open;

  always_comb begin
    sel           = reg_sel_e'(host_addr);
    acc_rd        = host_req & ~host_wr;
    acc_wr        = host_req &  host_wr;
    st_rd         = acc_rd && (sel == REG_STATUS);
    dat_rd_lo     = acc_rd && (sel == REG_DATA) && host_be[0];
    dat_wr_lo_try = acc_wr && (sel == REG_DATA) && host_be[0];
    dat_wr_hi_try = acc_wr && (sel == REG_DATA) && host_be[1];
    c1_wr         = acc_wr && (sel == REG_CTRL1) && host_be[0];
    c2_wr         = acc_wr && (sel == REG_CTRL2) && host_be[0];
  end

  // control registers
  logic [C1_W-1:0] ctrl1_q, ctrl1_d;
  logic            ctrl2_q, ctrl2_d;
  logic            ss_q;

  always_comb begin
    ctrl1_d = ctrl1_q;
    ctrl2_d = ctrl2_q;
    if (c1_wr) ctrl1_d = host_wdata[C1_W-1:0];
    if (c2_wr) ctrl2_d = host_wdata[C2_FDEN];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ctrl1_q <= '0;
      ctrl2_q <= 1'b0;
      ss_q    <= 1'b1;
    end else begin
      ctrl1_q <= ctrl1_d;
      ctrl2_q <= ctrl2_d;
      ss_q    <= ss_in_n;
    end
  end

  assign master_o = ctrl1_q[C1_MASTER];
  assign wide_o   = ctrl1_q[C1_WIDE];

  // flags
  logic [FLAG_N-1:0] flag_set, flag_access, flag_q, flag_armed;
  logic fault_edge;

  always_comb begin
    fault_edge          = ss_q & ~ss_in_n & master_o & ctrl2_q;
    flag_set            = '0;
    flag_access         = '0;
    flag_set[ST_RXF]    = eng_done;
    flag_set[ST_TXE]    = eng_load_taken;
    flag_set[ST_MF]     = fault_edge;
    flag_access[ST_RXF] = dat_rd_lo;
    flag_access[ST_TXE] = dat_wr_lo_try;
    flag_access[ST_MF]  = acc_wr && (sel == REG_CTRL1);
  end

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    spi_flag_cell #(.RESET_VAL(FLAG_RST[g])) u_cell (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .set_i    (flag_set[g]),
      .seen_i   (st_rd),
      .access_i (flag_access[g]),
      .flag_o   (flag_q[g]),
      .armed_o  (flag_armed[g])
    );
  end

  assign rx_full_o    = flag_q[ST_RXF];
  assign tx_empty_o   = flag_q[ST_TXE];
  assign mode_fault_o = flag_q[ST_MF];
  assign tx_open      = flag_q[ST_TXE];

  // data paths
  logic [DATA_W-1:0] rx_rd_word;

  spi_rx_buffer #(.BYTE_W(BYTE_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load_i    (eng_done),
    .word_i    (eng_rx_word),
    .wide_i    (wide_o),
    .rd_word_o (rx_rd_word)
  );

  spi_tx_holding #(.BYTE_W(BYTE_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_lo_i   (dat_wr_lo_try & tx_open),
    .wr_hi_i   (dat_wr_hi_try & tx_open),
    .wdata_i   (host_wdata),
    .wide_i    (wide_o),
    .tx_word_o (tx_word_o)
  );

  // read mux
  always_comb begin
    host_rdata = '0;
    unique case (sel)
      REG_STATUS: host_rdata[FLAG_N-1:0] = flag_q;
      REG_CTRL1:  host_rdata[C1_W-1:0]   = ctrl1_q;
      REG_CTRL2:  host_rdata[C2_FDEN]    = ctrl2_q;
      REG_DATA:   host_rdata             = rx_rd_word;
      default:    host_rdata             = '0;
    endcase
  end
endmodule

// File: rtl/spi_flag_frontend_chk.sv
module spi_flag_frontend_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_req,
  input logic              host_wr,
  input logic [1:0]        host_addr,
  input logic [1:0]        host_be,
  input logic              eng_done,
  input logic              eng_load_taken,
  input logic              ss_in_n,
  input logic              master_o,
  input logic              rx_full_o,
  input logic              tx_empty_o,
  input logic              mode_fault_o,
  input logic [DATA_W-1:0] tx_word_o
);
  logic rd_data_lo, rd_data_hi_only, wr_data, wr_data_lo, wr_data_hi_only, wr_c1, rd_status;
  assign rd_status       = host_req && !host_wr && host_addr == 2'd0;
  assign rd_data_lo      = host_req && !host_wr && host_addr == 2'd3 && host_be[0];
  assign rd_data_hi_only = host_req && !host_wr && host_addr == 2'd3 && host_be == 2'b10;
  assign wr_data         = host_req &&  host_wr && host_addr == 2'd3;
  assign wr_data_lo      = wr_data && host_be[0];
  assign wr_data_hi_only = wr_data && host_be == 2'b10;
  assign wr_c1           = host_req &&  host_wr && host_addr == 2'd1;

  logic rx_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rx_seen_q <= 1'b0;
    else if (rd_data_lo)              rx_seen_q <= 1'b0;
    else if (rd_status && rx_full_o)  rx_seen_q <= 1'b1;
  end

  assert_rxf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> rx_full_o);
  assert_rxf_clear_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full_o) |-> $past(rd_data_lo));
  assert_rxf_clear_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full_o) |-> $past(rx_seen_q));
  assert_hi_read_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_hi_only && rx_full_o) |=> rx_full_o);
  assert_txe_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_load_taken |=> tx_empty_o);
  assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !tx_empty_o) |=> $stable(tx_word_o));
  assert_txe_clear_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty_o) |-> $past(wr_data_lo));
  assert_hi_write_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_hi_only && !eng_load_taken) |=> $stable(tx_empty_o));
  assert_mf_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_fault_o) |-> $past(master_o && !ss_in_n));
  assert_mf_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_fault_o) |-> $past(wr_c1));
endmodule

bind spi_flag_frontend spi_flag_frontend_chk #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_core_n),
  .host_req       (host_req),
  .host_wr        (host_wr),
  .host_addr      (host_addr),
  .host_be        (host_be),
  .eng_done       (eng_done),
  .eng_load_taken (eng_load_taken),
  .ss_in_n        (ss_in_n),
  .master_o       (master_o),
  .rx_full_o      (rx_full_o),
  .tx_empty_o     (tx_empty_o),
  .mode_fault_o   (mode_fault_o),
  .tx_word_o      (tx_word_o)
);

// File: tb/spi_flag_frontend_tb_top.sv
`timescale 1ns/1ps
module spi_flag_frontend_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_wr = 1'b0;
  logic [1:0]  host_addr = 2'd0, host_be = 2'b00;
  logic [15:0] host_wdata = '0, host_rdata;
  logic        eng_done = 1'b0, eng_load_taken = 1'b0, ss_in_n = 1'b1;
  logic [15:0] eng_rx_word = '0, tx_word_o;
  logic        rx_full_o, tx_empty_o, mode_fault_o, master_o, wide_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] last_rd;

  always #10 clk = ~clk;

  spi_flag_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .eng_done(eng_done), .eng_rx_word(eng_rx_word),
    .eng_load_taken(eng_load_taken), .ss_in_n(ss_in_n), .tx_word_o(tx_word_o),
    .rx_full_o(rx_full_o), .tx_empty_o(tx_empty_o), .mode_fault_o(mode_fault_o),
    .master_o(master_o), .wide_o(wide_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_rxf, m_txe, m_mf, a_rx, a_tx, a_mf, m_ssq, m_master, m_wide, m_fden;
  int m_rxbuf, m_lo, m_hi;

  function automatic int model_rdata();
    case (host_addr)
      2'd0: return {m_mf, m_txe, m_rxf};
      2'd1: return {m_wide, m_master};
      2'd2: return m_fden;
      default: return m_wide ? m_rxbuf : (m_rxbuf & 'hFF);
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rxf = 0; m_txe = 1; m_mf = 0; a_rx = 0; a_tx = 0; a_mf = 0; m_ssq = 1;
      m_master = 0; m_wide = 0; m_fden = 0; m_rxbuf = 0; m_lo = 0; m_hi = 0;
    end else begin
      bit rd, wr, st, fault;
      rd = host_req && !host_wr; wr = host_req && host_wr;
      st = rd && host_addr == 0;
      fault = m_ssq && !ss_in_n && m_master && m_fden;
      // receive side
      if (eng_done) m_rxbuf = eng_rx_word;
      if (rd && host_addr == 3 && host_be[0]) begin
        if (a_rx) m_rxf = 0;
        a_rx = 0;
      end else if (st && m_rxf) a_rx = 1;
      if (eng_done) m_rxf = 1;
      // transmit side
      if (wr && host_addr == 3 && m_txe) begin
        if (host_be[1]) m_hi = host_wdata[15:8];
        if (host_be[0]) m_lo = host_wdata[7:0];
      end
      if (wr && host_addr == 3 && host_be[0]) begin
        if (a_tx) m_txe = 0;
        a_tx = 0;
      end else if (st && m_txe) a_tx = 1;
      if (eng_load_taken) m_txe = 1;
      // mode fault and control
      if (wr && host_addr == 1) begin
        if (a_mf) m_mf = 0;
        a_mf = 0;
      end else if (st && m_mf) a_mf = 1;
      if (fault) m_mf = 1;
      m_ssq = ss_in_n;
      if (wr && host_addr == 1 && host_be[0]) begin
        m_master = host_wdata[0]; m_wide = host_wdata[1];
      end
      if (wr && host_addr == 2 && host_be[0]) m_fden = host_wdata[0];
    end
  end

  always @(posedge clk) begin
    #5;
    if (!finished) begin
      chk("R3 model rx_full", rx_full_o, m_rxf);
      chk("R7 model tx_empty", tx_empty_o, m_txe);
      chk("R10 model mode_fault", mode_fault_o, m_mf);
      chk("R8 model tx_word", tx_word_o, m_wide ? ((m_hi << 8) | m_lo) : m_lo);
      chk("R5 model rdata", host_rdata, model_rdata());
    end
  end

  task automatic bus(input logic wr, input logic [1:0] a, input logic [1:0] be,
                     input logic [15:0] wd, input logic done, input logic [15:0] rxw);
    @(negedge clk);
    host_req = 1; host_wr = wr; host_addr = a; host_be = be; host_wdata = wd;
    eng_done = done; eng_rx_word = rxw;
    #5 last_rd = host_rdata;
    @(negedge clk);
    host_req = 0; host_wr = 0; eng_done = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [1:0] be);
    bus(1'b0, a, be, 16'h0, 1'b0, 16'h0);
  endtask
  task automatic wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
    bus(1'b1, a, be, d, 1'b0, 16'h0);
  endtask
  task automatic done_pulse(input logic [15:0] w);
    @(negedge clk); eng_done = 1; eng_rx_word = w;
    @(negedge clk); eng_done = 0;
  endtask
  task automatic taken_pulse();
    @(negedge clk); eng_load_taken = 1;
    @(negedge clk); eng_load_taken = 0;
  endtask
  task automatic set_ss(input logic v);
    @(negedge clk); ss_in_n = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 tx_empty", tx_empty_o, 1);
    chk("R1 rx_full", rx_full_o, 0);
    chk("R1 mode_fault", mode_fault_o, 0);
    rd(2'd0, 2'b01);
    chk("R2 status layout", last_rd, 16'h0002);
    // R2 receive narrow
    done_pulse(16'hA55A);
    chk("R2 rx set", rx_full_o, 1);
    rd(2'd3, 2'b01);
    chk("R5 narrow read", last_rd, 16'h005A);
    chk("R1 no arm after reset", rx_full_o, 1);
    rd(2'd0, 2'b01);
    chk("R2 status rx bit", last_rd, 16'h0003);
    rd(2'd3, 2'b01);
    chk("R3 armed clear", rx_full_o, 0);
    done_pulse(16'h1234);
    rd(2'd3, 2'b01);
    chk("R3 arm gone after clear", rx_full_o, 1);
    // R4 / R5 wide
    wr(2'd1, 2'b01, 16'h0002);
    chk("R5 wide bit", wide_o, 1);
    rd(2'd0, 2'b01);
    rd(2'd3, 2'b10);
    rd(2'd3, 2'b10);
    chk("R4 hi reads keep flag", rx_full_o, 1);
    chk("R5 wide read", last_rd, 16'h1234);
    rd(2'd3, 2'b01);
    chk("R4 arm kept through hi reads", rx_full_o, 0);
    // R11 set wins over clear
    done_pulse(16'hBEEF);
    rd(2'd0, 2'b01);
    bus(1'b0, 2'd3, 2'b11, 16'h0, 1'b1, 16'hCAFE);
    chk("R11 read saw old word", last_rd, 16'hBEEF);
    chk("R11 flag stays set", rx_full_o, 1);
    rd(2'd3, 2'b11);
    chk("R11 new word held", last_rd, 16'hCAFE);
    rd(2'd0, 2'b01);
    rd(2'd3, 2'b11);
    chk("R3 word read clear", rx_full_o, 0);
    // R8 / R7 transmit
    wr(2'd3, 2'b10, 16'hAB00);
    wr(2'd3, 2'b10, 16'hCD00);
    chk("R8 hi write keeps flag", tx_empty_o, 1);
    rd(2'd0, 2'b01);
    wr(2'd3, 2'b01, 16'h0011);
    chk("R7 low write clears", tx_empty_o, 0);
    chk("R8 last hi wins", tx_word_o, 16'hCD11);
    wr(2'd3, 2'b11, 16'hFFFF);
    chk("R6 busy write ignored", tx_word_o, 16'hCD11);
    taken_pulse();
    chk("R6 load taken sets", tx_empty_o, 1);
    wr(2'd3, 2'b11, 16'h5566);
    chk("R7 unarmed keeps flag", tx_empty_o, 1);
    chk("R7 unarmed stores data", tx_word_o, 16'h5566);
    rd(2'd0, 2'b01);
    wr(2'd3, 2'b11, 16'h7788);
    chk("R7 word write clears", tx_empty_o, 0);
    chk("R7 word loaded", tx_word_o, 16'h7788);
    wr(2'd1, 2'b01, 16'h0000);
    chk("R7 narrow tx upper zero", tx_word_o, 16'h0088);
    taken_pulse();
    // R9 / R10 mode fault
    wr(2'd1, 2'b01, 16'h0001);
    set_ss(1'b0);
    chk("R9 no fault without enable", mode_fault_o, 0);
    set_ss(1'b1);
    wr(2'd2, 2'b01, 16'h0001);
    set_ss(1'b0);
    chk("R9 fault on falling edge", mode_fault_o, 1);
    set_ss(1'b1);
    wr(2'd1, 2'b01, 16'h0001);
    chk("R10 unarmed ctrl write", mode_fault_o, 1);
    rd(2'd0, 2'b01);
    chk("R2 status mf bit", last_rd, 16'h0006);
    wr(2'd1, 2'b01, 16'h0001);
    chk("R10 armed ctrl write clears", mode_fault_o, 0);
    rd(2'd1, 2'b01);
    chk("R9 ctrl1 readback", last_rd, 16'h0001);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule